// File: doc/BRIEF.md
# Serial Configuration Sequencer for a Programmable Logic Target

This block brings up a programmable logic device that loads its configuration over a slave serial link. It owns the target's power enable, its active-low program request, the configuration clock and the serial data line. It watches the target's two status returns: the "ready for data" indication that follows the program pulse, and the "configuration complete" indication. A single `start` pulse runs the whole bring-up. The block switches on power and waits a settling time. It pulses program low, then waits for the ready indication. It then shifts exactly `img_len` image bytes out bit by bit, and keeps clocking until the target reports completion.

Image bytes arrive on a valid/ready byte stream. Whatever produces the stream (a decompressor, a flash reader) may raise `in_err` to abandon the load. Every wait carries a bound. The block ends each run with a one-cycle success pulse or a one-cycle error pulse, and `busy` covers the whole run. All delays are counted in system clock cycles and set by parameters.

Top module: `serial_cfg_sequencer`

## Requirements
- R1: After reset, `pwr_en`=0, `prog_n`=1, `cclk`=0, `din`=0, `busy`=0, `in_ready`=0, `ok_pulse`=0 and `err_pulse`=0. Asserting reset during a run returns all outputs to these values.
- R2: A `start` pulse in idle raises `busy` and `pwr_en` with `prog_n` high and `cclk`/`din` low. `prog_n` falls exactly PWR_CYC cycles after `busy` rises.
- R3: `prog_n` stays low for exactly PROG_CYC cycles, then returns high. It is never low while `pwr_en` is low.
- R4: After `prog_n` returns high, the ready input `init_i` is sampled through a two-flop synchronizer. No byte is accepted and no `cclk` edge occurs before it is seen high. If it is not seen high within INIT_POLLS cycles, `err_pulse` fires exactly INIT_POLLS cycles after the rising edge of `prog_n`.
- R5: Each byte is sent most significant bit first. `din` is stable across every rising edge of `cclk`, and each high or low phase of `cclk` lasts at least HALF_CYC cycles.
- R6: Exactly `img_len` bytes are accepted (handshakes where `in_valid` and `in_ready` are both 1), and `in_ready` is high only while `busy`.
- R7: `in_err` high while the block waits for a byte ends the run with `err_pulse`. No further byte is accepted and no further `cclk` rising edge occurs.
- R8: After the last byte, single `cclk` pulses continue while the synchronized `done_i` is low. Once it is seen high, `ok_pulse` fires. Because of the synchronizer, at most one extra pulse follows the rise of `done_i`.
- R9: If `done_i` never rises, exactly DONE_POLLS extra `cclk` pulses follow the last byte and then `err_pulse` fires.
- R10: Each run ends with exactly one of `ok_pulse` or `err_pulse`, one cycle wide, in the first cycle with `busy` low. `busy` stays high from `start` until then.
- R11: `start` while `busy` is ignored: the run continues and `prog_n` is pulsed only once.
- R12: With `img_len`=0, no byte is accepted and the block goes straight from the ready indication to completion clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| img_len | input | LEN_W | Number of image bytes, captured at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | `in_data` is valid |
| in_err | input | 1 | Source failure; abandons the run while waiting for a byte |
| in_ready | output | 1 | Block takes a byte this cycle if `in_valid` |
| pwr_en | output | 1 | Target power enable |
| prog_n | output | 1 | Active-low program request to target |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration serial data |
| init_i | input | 1 | Target ready-for-data indication (asynchronous) |
| done_i | input | 1 | Target configuration-complete indication (asynchronous) |
| busy | output | 1 | Run in progress |
| ok_pulse | output | 1 | One-cycle success indication |
| err_pulse | output | 1 | One-cycle failure indication |

## Verification
The hardest situation to reach is the end of the completion phase, where `done_i` rises partway through the trailing clock pulses. The synchronizer delay decides whether one more pulse goes out. The bench counts trailing `cclk` rising edges and raises `done_i` right after a chosen count, including a count of zero on the final data bit. It accepts the count or the count plus one. An input error is injected only at a chosen byte index, after earlier bytes have gone out, to show that clocking stops mid-image.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POWER,
        ST_PROG,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_SHIFT,
        ST_FLUSH
    } seq_state_e;

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] st_d [STAGES];
    logic [WIDTH-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                st_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                st_q[s] <= st_d[s];
            end
        end
    end

    assign sync_o = st_q[STAGES-1];

endmodule

// File: rtl/cfgseq_shifter.sv
module cfgseq_shifter #(
    parameter int BITS     = 8,
    parameter int HALF_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_byte,
    input  logic            load_pulse,
    input  logic [BITS-1:0] byte_in,
    output logic            cclk,
    output logic            din,
    output logic            idle
);

    localparam int TW  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BCW = $clog2(BITS + 1);

    typedef struct packed {
        logic            active;
        logic            high;
        logic            dbit;
        logic [BCW-1:0]  bits;
        logic [BITS-1:0] shreg;
        logic [TW-1:0]   timer;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!sh_q.active) begin
            if (load_byte) begin
                sh_d.active = 1'b1;
                sh_d.high   = 1'b0;
                sh_d.timer  = '0;
                sh_d.bits   = BCW'(BITS);
                sh_d.shreg  = byte_in;
                sh_d.dbit   = byte_in[BITS-1];
            end else if (load_pulse) begin
                // single clock pulse, data line left as it is
                sh_d.active = 1'b1;
                sh_d.high   = 1'b0;
                sh_d.timer  = '0;
                sh_d.bits   = BCW'(1);
            end
        end else if (sh_q.timer != TW'(HALF_CYC - 1)) begin
            sh_d.timer = sh_q.timer + 1'b1;
        end else begin
            sh_d.timer = '0;
            if (!sh_q.high) begin
                sh_d.high = 1'b1;
            end else begin
                sh_d.high  = 1'b0;
                sh_d.bits  = sh_q.bits - 1'b1;
                sh_d.shreg = sh_q.shreg << 1;
                if (sh_q.bits == BCW'(1)) begin
                    sh_d.active = 1'b0;
                end else begin
                    sh_d.dbit = sh_q.shreg[BITS-2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign cclk = sh_q.high;
    assign din  = sh_q.dbit;
    assign idle = !sh_q.active;

endmodule

// File: rtl/serial_cfg_sequencer.sv
module serial_cfg_sequencer
    import cfgseq_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int PWR_CYC    = 1200000,
    parameter int PROG_CYC   = 1200000,
    parameter int INIT_POLLS = 100000,
    parameter int DONE_POLLS = 100000,
    parameter int HALF_CYC   = 3,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] img_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_err,
    output logic             in_ready,
    output logic             pwr_en,
    output logic             prog_n,
    output logic             cclk,
    output logic             din,
    input  logic             init_i,
    input  logic             done_i,
    output logic             busy,
    output logic             ok_pulse,
    output logic             err_pulse
);

    localparam int MAXCNT = max4(PWR_CYC, PROG_CYC, INIT_POLLS, DONE_POLLS);
    localparam int CNT_W  = $clog2(MAXCNT + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] remain;
        logic             pwr;
        logic             prog_n;
        logic             ok;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;

    logic [1:0] stat_s;
    logic       init_s, done_s;
    logic       ld_byte, ld_pulse, sh_idle;

    cfgseq_sync #(.STAGES(SYNC_STG), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, init_i}),
        .sync_o  (stat_s)
    );
    assign init_s = stat_s[0];
    assign done_s = stat_s[1];

    cfgseq_shifter #(.BITS(8), .HALF_CYC(HALF_CYC)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_byte  (ld_byte),
        .load_pulse (ld_pulse),
        .byte_in    (in_data),
        .cclk       (cclk),
        .din        (din),
        .idle       (sh_idle)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ok   = 1'b0;
        s_d.err  = 1'b0;
        ld_byte  = 1'b0;
        ld_pulse = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.pwr    = 1'b1;
                    s_d.prog_n = 1'b1;
                    s_d.cnt    = '0;
                    s_d.remain = img_len;
                    s_d.state  = ST_POWER;
                end
            end
            ST_POWER: begin
                if (s_q.cnt == CNT_W'(PWR_CYC - 1)) begin
                    s_d.prog_n = 1'b0;
                    s_d.cnt    = '0;
                    s_d.state  = ST_PROG;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_PROG: begin
                if (s_q.cnt == CNT_W'(PROG_CYC - 1)) begin
                    s_d.prog_n = 1'b1;
                    s_d.cnt    = '0;
                    s_d.state  = ST_WAIT_INIT;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_WAIT_INIT: begin
                if (init_s) begin
                    s_d.cnt   = '0;
                    s_d.state = (s_q.remain == '0) ? ST_FLUSH : ST_FETCH;
                end else if (s_q.cnt == CNT_W'(INIT_POLLS - 1)) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_FETCH: begin
                if (in_err) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_IDLE;
                end else if (in_valid) begin
                    ld_byte    = 1'b1;
                    s_d.remain = s_q.remain - 1'b1;
                    s_d.state  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_idle) begin
                    s_d.cnt   = '0;
                    s_d.state = (s_q.remain == '0) ? ST_FLUSH : ST_FETCH;
                end
            end
            ST_FLUSH: begin
                if (sh_idle) begin
                    if (done_s) begin
                        s_d.ok    = 1'b1;
                        s_d.state = ST_IDLE;
                    end else if (s_q.cnt == CNT_W'(DONE_POLLS)) begin
                        s_d.err   = 1'b1;
                        s_d.state = ST_IDLE;
                    end else begin
                        ld_pulse = 1'b1;
                        s_d.cnt  = s_q.cnt + 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.state  <= ST_IDLE;
            s_q.prog_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.state == ST_FETCH);
    assign busy      = (s_q.state != ST_IDLE);
    assign pwr_en    = s_q.pwr;
    assign prog_n    = s_q.prog_n;
    assign ok_pulse  = s_q.ok;
    assign err_pulse = s_q.err;

endmodule

// File: rtl/cfgseq_checks.sv
module cfgseq_checks (
    input logic clk,
    input logic rst_n,
    input logic pwr_en,
    input logic prog_n,
    input logic cclk,
    input logic din,
    input logic busy,
    input logic in_ready,
    input logic ok_pulse,
    input logic err_pulse
);

    // R2: power comes up with program released and serial lines low
    a_r2_power_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> (prog_n && !cclk && !din));

    // R3: program request only with power on
    a_r3_prog_powered: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> pwr_en);

    // R5: data steady at each rising clock edge
    a_r5_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> $stable(din));

    // R6: bytes only taken during a run, after power and program release
    a_r6_ready_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && prog_n && pwr_en));

    // R7: no configuration clock outside a run
    a_r7_clk_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cclk);

    // R10: result pulses exclusive, single cycle, with busy low
    a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_pulse && err_pulse));
    a_r10_ok_width: assert property (@(posedge clk) disable iff (!rst_n)
        ok_pulse |=> !ok_pulse);
    a_r10_err_width: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
    a_r10_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_pulse || err_pulse) |-> !busy);
    a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ok_pulse || err_pulse));

endmodule

bind serial_cfg_sequencer cfgseq_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en    (pwr_en),
    .prog_n    (prog_n),
    .cclk      (cclk),
    .din       (din),
    .busy      (busy),
    .in_ready  (in_ready),
    .ok_pulse  (ok_pulse),
    .err_pulse (err_pulse)
);

// File: tb/tb_serial_cfg_sequencer.sv
module tb_serial_cfg_sequencer;

    localparam int LEN_W      = 16;
    localparam int PWR_CYC    = 20;
    localparam int PROG_CYC   = 15;
    localparam int INIT_POLLS = 40;
    localparam int DONE_POLLS = 30;
    localparam int HALF_CYC   = 2;

    typedef struct packed {
        int len;
        int init_dly;    // -1: ready never rises
        int done_after;  // -1: completion never rises
        int err_at;      // -1: no source error
        int poke;        // 1: extra start while busy
        int exp_ok;
    } case_t;

    localparam int NCASE = 7;
    localparam case_t CASES [NCASE] = '{
        '{4,  5,  3, -1, 0, 1},
        '{1,  0,  0, -1, 0, 1},
        '{0,  3,  2, -1, 0, 1},
        '{3, -1,  2, -1, 0, 0},
        '{5,  2, -1, -1, 0, 0},
        '{6,  1,  1,  2, 0, 0},
        '{3,  4,  4, -1, 1, 1}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [LEN_W-1:0] img_len = '0;
    logic [7:0] in_data = '0;
    logic in_valid = 0;
    logic in_err = 0;
    logic in_ready, pwr_en, prog_n, cclk, din, busy, ok_pulse, err_pulse;
    logic init_i = 0;
    logic done_i = 0;

    always #5 clk = ~clk;

    serial_cfg_sequencer #(
        .LEN_W(LEN_W), .PWR_CYC(PWR_CYC), .PROG_CYC(PROG_CYC),
        .INIT_POLLS(INIT_POLLS), .DONE_POLLS(DONE_POLLS), .HALF_CYC(HALF_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
        .in_data(in_data), .in_valid(in_valid), .in_err(in_err),
        .in_ready(in_ready), .pwr_en(pwr_en), .prog_n(prog_n),
        .cclk(cclk), .din(din), .init_i(init_i), .done_i(done_i),
        .busy(busy), .ok_pulse(ok_pulse), .err_pulse(err_pulse)
    );

    int checks = 0;
    int fails = 0;
    int wd_fail = 0;

    function automatic logic [7:0] pat(int idx, int seed);
        return 8'((idx * 37 + seed * 11 + 8'h5A) & 8'hFF);
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks + wd_fail, fails + wd_fail);
    endtask

    // per-case configuration read by the monitor
    int case_id = 0;
    int len_cur = 0;
    int seed_cur = 0;
    int init_dly_cur = -1;
    int done_after_cur = -1;

    // monitor state
    int seen_id = 0;
    int cyc = 0;
    int t_busy, t_pfall, t_prise, t_err, t_edge;
    int n_pfall, acc, rises_data, flush, late_rises, dmis, half_bad;
    int n_ok, n_err, bad_busy;
    bit result_seen;
    logic [7:0] asm_b;
    logic busy_p = 0, prog_p = 1, cclk_p = 0;

    always @(negedge clk) begin
        cyc++;
        if (case_id != seen_id) begin
            seen_id = case_id;
            t_busy = -1; t_pfall = -1; t_prise = -1; t_err = -1; t_edge = -1;
            n_pfall = 0; acc = 0; rises_data = 0; flush = 0; late_rises = 0;
            dmis = 0; half_bad = 0; n_ok = 0; n_err = 0; bad_busy = 0;
            result_seen = 0; asm_b = '0;
            init_i = 0; done_i = 0;
        end else begin
            if (busy && !busy_p) t_busy = cyc;
            if (!prog_n && prog_p) begin t_pfall = cyc; n_pfall++; end
            if (prog_n && !prog_p) t_prise = cyc;
            if (init_dly_cur >= 0 && t_prise >= 0 && (cyc - t_prise) >= init_dly_cur) init_i = 1;
            if (in_valid && in_ready) acc++;
            if (cclk != cclk_p) begin
                if (t_edge >= 0 && (cyc - t_edge) < HALF_CYC) half_bad++;
                t_edge = cyc;
            end
            if (cclk && !cclk_p) begin
                if (result_seen) late_rises++;
                if (rises_data < len_cur * 8) begin
                    asm_b = {asm_b[6:0], din};
                    rises_data++;
                    if (rises_data % 8 == 0 && asm_b != pat(rises_data / 8 - 1, seed_cur)) dmis++;
                end else begin
                    flush++;
                end
            end
            if (done_after_cur >= 0 && init_i && acc == len_cur &&
                rises_data == len_cur * 8 && flush >= done_after_cur) done_i = 1;
            if (ok_pulse) n_ok++;
            if (err_pulse) begin n_err++; t_err = cyc; end
            if ((ok_pulse || err_pulse) && busy) bad_busy++;
            if (!busy && busy_p && !(ok_pulse || err_pulse)) bad_busy++;
            if (ok_pulse || err_pulse) result_seen = 1;
        end
        busy_p = busy; prog_p = prog_n; cclk_p = cclk;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd_fail = 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic run_case(input int ci);
        case_t c;
        bit got;
        int tmo;
        int exp_acc;
        c = CASES[ci];
        len_cur = c.len; seed_cur = ci;
        init_dly_cur = c.init_dly; done_after_cur = c.done_after;
        img_len = LEN_W'(c.len);
        case_id++;
        repeat (2) @(posedge clk);
        #1 start = 1;
        @(posedge clk); #1 start = 0;
        for (int i = 0; i < c.len; i++) begin
            if (i == c.err_at) begin
                in_err = 1;
                while (!result_seen) begin @(posedge clk); #2; end
                @(posedge clk); #1 in_err = 0;
                break;
            end
            in_data = pat(i, ci);
            in_valid = 1;
            got = 0;
            while (!got && !result_seen) begin
                if (in_ready) got = 1;
                else begin @(posedge clk); #2; end
            end
            @(posedge clk); #1 in_valid = 0;
            if (!got) break;
            if (c.poke != 0 && i == 0) begin
                start = 1; @(posedge clk); #1 start = 0;
            end
            if (i % 2 == 1) begin @(posedge clk); #1; end
        end
        tmo = 0;
        while (!result_seen && tmo < 4000) begin @(posedge clk); #2; tmo++; end
        repeat (6) @(posedge clk);
        #2;
        exp_acc = (c.init_dly < 0) ? 0 : ((c.err_at >= 0) ? c.err_at : c.len);

        // R10: one result pulse, busy low with it
        check(n_ok + n_err == 1 && bad_busy == 0, "R10 single result", n_ok + n_err, 1);
        check(n_ok == c.exp_ok, c.exp_ok != 0 ? "R8 success result" : "R9/R4/R7 error result", n_ok, c.exp_ok);
        // R2 / R3 timing
        check(t_pfall - t_busy == PWR_CYC, "R2 power settle", t_pfall - t_busy, PWR_CYC);
        check(t_prise - t_pfall == PROG_CYC, "R3 program low", t_prise - t_pfall, PROG_CYC);
        // R6 byte count and R5 order/timing
        check(acc == exp_acc, "R6 bytes accepted", acc, exp_acc);
        check(rises_data == exp_acc * 8, "R6 data bits sent", rises_data, exp_acc * 8);
        check(dmis == 0, "R5 MSB first data", dmis, 0);
        check(half_bad == 0, "R5 half period", half_bad, 0);
        check(late_rises == 0, "R7 no clock after end", late_rises, 0);
        // R11 single program pulse
        check(n_pfall == 1, "R11 one program pulse", n_pfall, 1);
        if (c.init_dly < 0) begin
            check(t_err - t_prise == INIT_POLLS, "R4 ready timeout", t_err - t_prise, INIT_POLLS);
            check(flush == 0, "R4 no clock before ready", flush, 0);
        end else if (c.err_at >= 0) begin
            check(flush == 0, "R7 no trailing clocks", flush, 0);
        end else if (c.done_after < 0) begin
            check(flush == DONE_POLLS, "R9 trailing pulse limit", flush, DONE_POLLS);
        end else begin
            check(flush >= c.done_after && flush <= c.done_after + 1,
                  c.len == 0 ? "R12 empty image clocks" : "R8 trailing pulses", flush, c.done_after);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check(pwr_en == 0 && prog_n == 1 && cclk == 0 && din == 0, "R1 reset pins",
              {pwr_en, prog_n, cclk, din}, 4'b0100);
        check(busy == 0 && in_ready == 0 && ok_pulse == 0 && err_pulse == 0, "R1 reset status",
              {busy, in_ready, ok_pulse, err_pulse}, 0);
        @(posedge clk); #1 rst_n = 1;
        repeat (3) @(posedge clk);

        for (int ci = 0; ci < NCASE; ci++) run_case(ci);

        // R1: reset in the middle of a run
        len_cur = 2; seed_cur = 9; init_dly_cur = 0; done_after_cur = 0;
        img_len = LEN_W'(2);
        case_id++;
        repeat (2) @(posedge clk);
        #1 start = 1;
        @(posedge clk); #1 start = 0;
        repeat (PWR_CYC + 5) @(posedge clk);
        #2;
        check(busy == 1 && pwr_en == 1 && prog_n == 0, "R2 run under way", {busy, pwr_en, prog_n}, 3'b110);
        rst_n = 0;
        #1;
        check(pwr_en == 0 && prog_n == 1 && cclk == 0 && busy == 0 && in_ready == 0,
              "R1 mid-run reset", {pwr_en, prog_n, cclk, busy, in_ready}, 5'b01000);
        @(posedge clk); #1 rst_n = 1;
        repeat (3) @(posedge clk);
        #2;
        check(busy == 0 && prog_n == 1, "R1 stays idle after reset", {busy, prog_n}, 2'b01);

        summary();
        $finish;
    end

endmodule